// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. A request gives a starting column, a burst length (two, four, eight beats or a whole row) and an ordering (sequential or interleaved), qualified by a start strobe. From the next cycle on, the block presents one column address per clock, with a valid flag and, for fixed-length bursts, a flag marking the final beat.

Only the low column bits inside the burst window move. In sequential order they count up from the starting offset and wrap inside the window. In interleaved order each beat's offset is the starting offset XOR the beat number. The bits above the window keep their starting value. A whole-row burst always counts sequentially over all 256 columns and wraps round the row until the stop input ends it. The stop input can also cut a fixed-length burst short.

Top module: `burst_colgen`

## Requirements
- R1: After reset, `validOut` and `lastOut` are low.
- R2: With `validOut` low, a high `startIn` at a clock edge captures the request. Beat 0 appears in the cycle after that edge, with `colOut` equal to `startCol`. Without a start the block stays idle.
- R3: `lenSel` encodes 0 = 2 beats, 1 = 4 beats, 2 = 8 beats and 3 = whole row. A fixed burst shows exactly that many valid beats on consecutive cycles. `lastOut` is high on the final beat only, and `validOut` is low the cycle after.
- R4: With `interleaveIn` = 0, the window offset of beat i is (start offset + i) modulo the burst length. The window is the low 1, 2 or 3 bits for lengths 2, 4 and 8. Example: length 4, offset 1 gives 1,2,3,0.
- R5: With `interleaveIn` = 1, the window offset of beat i is start offset XOR i. Example: length 8, offset 5 gives 5,4,7,6,1,0,3,2. For length 2 this matches the sequential order.
- R6: For fixed bursts, the column bits above the window equal those of `startCol` on every beat.
- R7: A whole-row burst steps the full 8-bit column by one per beat, wrapping from 255 to 0, whatever the value of `interleaveIn`. It never raises `lastOut` and keeps running until stopped.
- R8: A high `stopIn` during a valid beat makes that beat the final one, and `validOut` is low the next cycle. A high `stopIn` while idle has no effect.
- R9: A high `startIn` while `validOut` is high is ignored. The burst in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Request strobe, taken only while idle |
| startCol | input | 8 | Starting column address |
| lenSel | input | 2 | Burst length code (0:2, 1:4, 2:8, 3:whole row) |
| interleaveIn | input | 1 | 1 selects interleaved order for fixed lengths |
| stopIn | input | 1 | Ends the burst after the current beat |
| colOut | output | 8 | Column address of the current beat |
| validOut | output | 1 | A beat is presented this cycle |
| lastOut | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
The hardest case to reach from the ports is the wrap of a whole-row burst past column 255. It only happens after many beats, with a high starting column, and with the stop held off until after the wrap. The stimulus starts whole-row bursts near the top of the row and runs one of them past 256 beats before raising `stopIn`. Interleave is requested on one of these runs to show that it is overridden. Mid-burst start strobes carrying different settings are injected, and the scoreboard rejects any beat that does not belong to the original request.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef enum logic [1:0] {
    BL_TWO   = 2'd0,
    BL_FOUR  = 2'd1,
    BL_EIGHT = 2'd2,
    BL_ROW   = 2'd3
  } burstLen_e;

  typedef struct packed {
    logic load;
    logic step;
    logic halt;
  } ctrlStrobe_t;
endpackage

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             stopIn,
  input  burstLen_e        lenSel,
  output ctrlStrobe_t      strobe,
  output logic [COL_W-1:0] beatIdx,
  output logic             validOut,
  output logic             lastOut
);
  logic             active;
  logic [COL_W-1:0] beatCnt;
  burstLen_e        lenReg;
  logic [COL_W-1:0] finalIdx;
  logic             finalBeat;

  always_comb begin
    finalIdx = (COL_W'(1) << (int'(lenReg) + 1)) - COL_W'(1);
  end

  assign finalBeat   = active && (lenReg != BL_ROW) && (beatCnt == finalIdx);
  assign strobe.load = startIn && !active;
  assign strobe.halt = active && (finalBeat || stopIn);
  assign strobe.step = active && !(finalBeat || stopIn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      beatCnt <= '0;
      lenReg  <= BL_TWO;
    end else if (strobe.load) begin
      active  <= 1'b1;
      beatCnt <= '0;
      lenReg  <= lenSel;
    end else if (strobe.halt) begin
      active  <= 1'b0;
      beatCnt <= '0;
    end else if (strobe.step) begin
      beatCnt <= beatCnt + COL_W'(1);
    end
  end

  assign beatIdx  = beatCnt;
  assign validOut = active;
  assign lastOut  = finalBeat;
endmodule

// File: rtl/colgen_datapath.sv
module colgen_datapath
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [COL_W-1:0] startCol,
  input  burstLen_e        lenSel,
  input  logic             interleaveIn,
  input  logic [COL_W-1:0] beatIdx,
  output logic [COL_W-1:0] colOut,
  output logic             isRow,
  output logic             isInter
);
  logic [COL_W-1:0] baseCol;
  burstLen_e        lenReg;
  logic             interReg;
  logic [COL_W-1:0] winMask;
  logic [COL_W-1:0] seqOff;
  logic [COL_W-1:0] xorOff;
  logic [COL_W-1:0] pickOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCol  <= '0;
      lenReg   <= BL_TWO;
      interReg <= 1'b0;
    end else if (strobe.load) begin
      baseCol  <= startCol;
      lenReg   <= lenSel;
      interReg <= interleaveIn && (lenSel != BL_ROW);
    end
  end

  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign winMask[b] = (lenReg == BL_ROW) || (b < int'(lenReg) + 1);
  end

  assign seqOff  = baseCol + beatIdx;
  assign xorOff  = baseCol ^ beatIdx;
  assign pickOff = interReg ? xorOff : seqOff;
  assign colOut  = (baseCol & ~winMask) | (pickOff & winMask);
  assign isRow   = (lenReg == BL_ROW);
  assign isInter = interReg;
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [COL_W-1:0] startCol,
  input  logic [1:0]       lenSel,
  input  logic             interleaveIn,
  input  logic             stopIn,
  output logic [COL_W-1:0] colOut,
  output logic             validOut,
  output logic             lastOut
);
  ctrlStrobe_t      strobe;
  logic [COL_W-1:0] beatIdx;
  logic             isRow;
  logic             isInter;
  burstLen_e        lenCode;

  assign lenCode = burstLen_e'(lenSel);

  colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .stopIn(stopIn),
    .lenSel(lenCode), .strobe(strobe), .beatIdx(beatIdx),
    .validOut(validOut), .lastOut(lastOut)
  );

  colgen_datapath #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startCol(startCol),
    .lenSel(lenCode), .interleaveIn(interleaveIn), .beatIdx(beatIdx),
    .colOut(colOut), .isRow(isRow), .isInter(isInter)
  );
endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startIn,
  input logic             stopIn,
  input logic [COL_W-1:0] colOut,
  input logic             validOut,
  input logic             lastOut,
  input logic             isRow
);
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    lastOut |-> validOut); // R3
  AST_CONTINUE_BURST: assert property (@(posedge clk) disable iff (!rstN)
    validOut && !lastOut && !stopIn |=> validOut); // R3
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    !validOut && !startIn |=> !validOut); // R2
  AST_END_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    validOut && (lastOut || stopIn) |=> !validOut); // R8
  AST_ROW_NO_LAST: assert property (@(posedge clk) disable iff (!rstN)
    validOut && isRow |-> !lastOut); // R7
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rstN)
    validOut && isRow && !stopIn |=> colOut == COL_W'($past(colOut) + 1'b1)); // R7
  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    validOut && !isRow && !lastOut && !stopIn |=>
      colOut[COL_W-1:3] == $past(colOut[COL_W-1:3])); // R6
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rstN)
    validOut && startIn && !lastOut && !stopIn |=> validOut && $stable(isRow)); // R9
endmodule

bind burst_colgen colgen_checker #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .stopIn(stopIn),
  .colOut(colOut), .validOut(validOut), .lastOut(lastOut), .isRow(isRow)
);

// File: tb/test_burst_colgen.sv
module test_burst_colgen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startIn = 1'b0;
  logic [7:0] startCol = '0;
  logic [1:0] lenSel = '0;
  logic       interleaveIn = 1'b0;
  logic       stopIn = 1'b0;
  logic [7:0] colOut;
  logic       validOut;
  logic       lastOut;

  int checks = 0;
  int fails = 0;
  bit monOn = 1'b0;

  typedef struct {
    logic [7:0] col;
    logic       last;
    string      tag;
  } item_t;
  item_t expQ[$];

  always #2 clk = ~clk;

  burst_colgen i_burst_colgen (
    .clk(clk), .rstN(rstN), .startIn(startIn), .startCol(startCol),
    .lenSel(lenSel), .interleaveIn(interleaveIn), .stopIn(stopIn),
    .colOut(colOut), .validOut(validOut), .lastOut(lastOut)
  );

  function automatic logic [7:0] expCol(logic [7:0] s, logic [1:0] l, logic il, int i);
    int n;
    int m;
    int off;
    if (l == 2'd3) return 8'((int'(s) + i) % 256);
    n = 2 << l;
    m = n - 1;
    if (il) off = (int'(s) & m) ^ i;
    else    off = ((int'(s) & m) + i) % n;
    return 8'((int'(s) & ~m) | off);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected beat for each valid cycle
  always @(negedge clk) begin
    if (monOn && validOut) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9/R8 unexpected beat", int'(colOut), -1);
      end else begin
        item_t e;
        e = expQ.pop_front();
        check(colOut == e.col, e.tag, int'(colOut), int'(e.col));
        check(lastOut == e.last, {e.tag, " last"}, int'(lastOut), int'(e.last));
      end
    end
  end

  // Fixed burst; optionally inject an ignored start at beat 1 (R9)
  task automatic runFixed(logic [7:0] s, logic [1:0] l, logic il, string tag, bit poke);
    int n;
    n = 2 << l;
    for (int i = 0; i < n; i++) begin
      item_t e;
      e.col = expCol(s, l, il, i);
      e.last = (i == n - 1);
      e.tag = tag;
      expQ.push_back(e);
    end
    @(negedge clk);
    startIn = 1'b1; startCol = s; lenSel = l; interleaveIn = il;
    @(negedge clk);
    startIn = 1'b0;
    if (poke) begin
      @(negedge clk);
      startIn = 1'b1; startCol = ~s; lenSel = 2'd3; interleaveIn = ~il;
      @(negedge clk);
      startIn = 1'b0;
      repeat (n - 2) @(negedge clk);
    end else begin
      repeat (n) @(negedge clk);
    end
    check(validOut == 1'b0, "R3 ends after final beat", int'(validOut), 0);
    check(expQ.size() == 0, "R3 beat count", expQ.size(), 0);
  endtask

  // Burst stopped after k beats
  task automatic runStopped(logic [7:0] s, logic [1:0] l, logic il, int k, string tag);
    for (int i = 0; i < k; i++) begin
      item_t e;
      e.col = expCol(s, l, il, i);
      e.last = 1'b0;
      e.tag = tag;
      expQ.push_back(e);
    end
    @(negedge clk);
    startIn = 1'b1; startCol = s; lenSel = l; interleaveIn = il;
    @(negedge clk);
    startIn = 1'b0;
    repeat (k - 1) @(negedge clk);
    stopIn = 1'b1;
    @(negedge clk);
    stopIn = 1'b0;
    check(validOut == 1'b0, "R8 stop ends burst", int'(validOut), 0);
    check(expQ.size() == 0, "R8 beat count", expQ.size(), 0);
  endtask

  initial begin
    #800000;
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(validOut == 1'b0, "R1 valid after reset", int'(validOut), 0);
    check(lastOut == 1'b0, "R1 last after reset", int'(lastOut), 0);
    // R8: stop while idle, R2: no start keeps idle
    stopIn = 1'b1;
    repeat (3) @(negedge clk);
    stopIn = 1'b0;
    check(validOut == 1'b0, "R8 stop while idle", int'(validOut), 0);
    monOn = 1'b1;

    runFixed(8'h40, 2'd0, 1'b0, "R2 R5 len2 seq", 1'b0);
    runFixed(8'h41, 2'd0, 1'b0, "R4 len2 seq start1", 1'b0);
    runFixed(8'h41, 2'd0, 1'b1, "R5 len2 inter start1", 1'b0);
    runFixed(8'hA1, 2'd1, 1'b0, "R4 len4 seq", 1'b0);
    runFixed(8'hA2, 2'd1, 1'b1, "R5 len4 inter", 1'b0);
    runFixed(8'hD5, 2'd2, 1'b1, "R5 R6 len8 inter", 1'b0);
    runFixed(8'h7E, 2'd2, 1'b0, "R4 R6 len8 seq", 1'b0);
    runFixed(8'h33, 2'd2, 1'b0, "R9 start ignored", 1'b1);
    runFixed(8'hFF, 2'd1, 1'b1, "R9 R6 start ignored", 1'b1);
    for (int s = 0; s < 8; s++) begin
      runFixed(8'(8'h18 + s), 2'd2, 1'b1, "R5 len8 inter sweep", 1'b0);
      runFixed(8'(8'hE8 + s), 2'd2, 1'b0, "R4 len8 seq sweep", 1'b0);
    end
    runStopped(8'hFA, 2'd3, 1'b0, 270, "R7 row wrap");
    runStopped(8'hF0, 2'd3, 1'b1, 40, "R7 row ignores interleave");
    runStopped(8'h05, 2'd3, 1'b0, 1, "R8 row stop at beat0");
    runStopped(8'h2C, 2'd2, 1'b0, 3, "R8 fixed stopped early");
    runFixed(8'h12, 2'd1, 1'b0, "R2 after stop", 1'b0);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R3 scoreboard drained", expQ.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule